// File: doc/BRIEF.md
# Fractional Baud Oversample Tick Generator

This block derives the 16x oversampling strobe for a serial port from the system clock with a phase accumulator. Every active cycle a programmable integer increment is added to an N-bit phase register. Each time the addition carries out of the top bit, a single-cycle strobe (`tick_x16`) is issued. Because the increment need not divide the phase range evenly, the strobe spacing changes by one cycle from strobe to strobe. The long-run strobe rate is exactly f_clk × inc / 2^N.

The strobe rate is 16 times the baud rate, so f_baud = f_clk × inc / (16 × 2^N). Software picks inc = 16 × 2^N × f_baud / f_clk and rounds it down to an integer. Rounding down means the achieved rate never exceeds the requested one. A second strobe, `tick_1x`, marks every sixteenth `tick_x16` and sets the transmitter's bit timing. The receiver uses `tick_x16` directly for oversampling.

A two-state controller gates the accumulator. In `NCO_HALT` the phase and the sixteenth-counter hold their values and no strobes are issued. In `NCO_RUN` the accumulator adds the increment once per cycle. The controller moves from `NCO_HALT` to `NCO_RUN` (transition *start*) at the first clock edge that sees the enable high and a non-zero increment. It moves from `NCO_RUN` back to `NCO_HALT` (transition *stop*) at the first edge that sees the enable low or a zero increment. Otherwise it stays where it is (*keep*).

Top module: `baud_nco_gen`

## Requirements
- R1: While `rst_n` is low, and at the first clock after its release, `tick_x16` and `tick_1x` are low. Reset clears the phase register and the sixteenth-counter to zero.
- R2: Starting from reset, after E accumulating cycles with a constant increment `inc`, exactly floor(E × inc / 2^N) `tick_x16` pulses have been issued. Each pulse lasts one cycle and follows the carry by one register stage.
- R3: The controller enters `NCO_RUN` at the clock edge that samples `en` = 1 and `nco_inc` ≠ 0. Accumulation starts on the following edge, so `en` held high for E cycles yields E additions.
- R4: When `en` is low the phase register holds its value and no `tick_x16` is issued. After a pause, accumulation continues from the held phase.
- R5: `tick_1x` pulses together with every sixteenth `tick_x16`, counted from reset. Its total is floor(x16 total / 16).
- R6: An increment of zero behaves like a low enable: no strobes, and the phase is kept for later non-zero increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for the oscillator |
| nco_inc | input | ACC_W | Phase increment per cycle |
| tick_x16 | output | 1 | One-cycle 16x oversample strobe |
| tick_1x | output | 1 | One-cycle strobe on every sixteenth `tick_x16` |

## Verification
The hardest behaviour to reach from the ports is phase retention across a pause. A design that cleared the phase on halt would still issue the right number of strobes whenever each run segment ends on a carry boundary. The stimulus therefore uses an increment of 3/8 of the phase range and splits it into two five-add segments, each of which leaves a fractional remainder. It separates them once with the enable low and once with a zero increment. A retained phase gives three strobes in total, while a cleared phase gives only two.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;
    typedef enum logic {
        NCO_HALT = 1'b0,
        NCO_RUN  = 1'b1
    } nco_state_e;
endpackage

// File: rtl/baud_nco_ctrl.sv
module baud_nco_ctrl
    import baud_nco_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] nco_inc,
    output logic             run
);
    nco_state_e state_q, state_d;
    logic       go;

    assign go = en && (nco_inc != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NCO_HALT: if (go)  state_d = NCO_RUN;   // start
            NCO_RUN:  if (!go) state_d = NCO_HALT;  // stop
            default:           state_d = NCO_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NCO_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == NCO_RUN);
    end

    // R3: an enabled non-zero increment puts the controller in run
    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> run);
    // R6: a zero increment always leads to halt
    assert_zero_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nco_inc == '0) |=> !run);
endmodule

// File: rtl/baud_nco_accum.sv
module baud_nco_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] nco_inc,
    output logic             tick
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, phase_q} + {1'b0, nco_inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            tick    <= 1'b0;
        end else if (run) begin
            phase_q <= sum[ACC_W-1:0];
            tick    <= sum[ACC_W];
        end else begin
            tick    <= 1'b0;
        end
    end

    // R4: the phase is frozen while halted
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(phase_q));
    // R4: no strobe follows a halted cycle
    assert_no_tick_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);
    // R2: a strobe is only possible after an accumulating cycle
    assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(run));
endmodule

// File: rtl/baud_nco_div.sv
module baud_nco_div #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_out
);
    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_in) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign tick_out = tick_in && (cnt_q == LAST);

    // R5: the counter moves only on an incoming strobe
    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(cnt_q));
    // R5: an output strobe returns the counter to zero
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |=> (cnt_q == '0));
endmodule

// File: rtl/baud_nco_gen.sv
module baud_nco_gen #(
    parameter int ACC_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] nco_inc,
    output logic             tick_x16,
    output logic             tick_1x
);
    logic run;

    baud_nco_ctrl #(.ACC_W(ACC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .nco_inc(nco_inc), .run(run));

    baud_nco_accum #(.ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .run(run), .nco_inc(nco_inc), .tick(tick_x16));

    baud_nco_div #(.OVS(OVS)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_x16), .tick_out(tick_1x));

    // R1: no strobes at the first clock after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tick_x16 && !tick_1x));
endmodule

// File: tb/baud_nco_gen_test.sv
module baud_nco_gen_test;
    localparam int ACC_W = 16;
    localparam int NVEC  = 7;

    localparam logic [ACC_W-1:0] VEC_INC [NVEC] = '{
        16'h8000, 16'hFFFF, 16'h0001, 16'h1000, 16'h6000, 16'h0A3D, 16'h2AAB };
    localparam int VEC_ADDS [NVEC] = '{ 64, 100, 1000, 320, 37, 5000, 3000 };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [ACC_W-1:0] nco_inc = '0;
    logic             tick_x16, tick_1x;

    int checks = 0;
    int failures = 0;
    int n16 = 0;
    int n1 = 0;

    always #10 clk = ~clk;

    baud_nco_gen #(.ACC_W(ACC_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .nco_inc(nco_inc),
        .tick_x16(tick_x16), .tick_1x(tick_1x));

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            n16 += int'(tick_x16);
            n1  += int'(tick_1x);
        end
    endtask

    task automatic do_reset();
        en = 1'b0;
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        n16 = 0;
        n1 = 0;
    endtask

    task automatic run_adds(input logic [ACC_W-1:0] inc, input int adds);
        nco_inc = inc;
        en = 1'b1;
        cyc(adds);
        en = 1'b0;
        cyc(3);
    endtask

    function automatic longint expect16(input longint inc, input longint adds);
        return (inc * adds) >> ACC_W;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        // R1: strobes stay low while reset is held, even with enable high
        nco_inc = 16'h8000;
        en = 1'b1;
        cyc(10);
        check("R1 x16 during reset", n16, 0);
        check("R1 1x during reset", n1, 0);
        en = 1'b0;
        rst_n = 1'b1;
        cyc(1);
        check("R1 x16 after release", tick_x16, 0);

        // R2 / R3 / R5: table of increments and add counts
        for (int v = 0; v < NVEC; v++) begin
            longint e16;
            do_reset();
            run_adds(VEC_INC[v], VEC_ADDS[v]);
            e16 = expect16(longint'(VEC_INC[v]), longint'(VEC_ADDS[v]));
            check($sformatf("R2 R3 vec%0d x16 count", v), n16, e16);
            check($sformatf("R5 vec%0d 1x count", v), n1, e16 / 16);
        end

        // R4: enable low means no strobes
        do_reset();
        nco_inc = 16'h8000;
        en = 1'b0;
        cyc(100);
        check("R4 disabled x16", n16, 0);

        // R4: phase is retained across an enable pause (3/8 step, 5+5 adds)
        do_reset();
        run_adds(16'h6000, 5);
        cyc(10);
        run_adds(16'h6000, 5);
        check("R4 phase kept over pause", n16, 3);

        // R6: zero increment with enable high gives no strobes
        do_reset();
        nco_inc = '0;
        en = 1'b1;
        cyc(100);
        en = 1'b0;
        cyc(2);
        check("R6 zero inc x16", n16, 0);

        // R6: phase is retained across a stretch of zero increment
        do_reset();
        run_adds(16'h6000, 5);
        run_adds(16'h0000, 20);
        run_adds(16'h6000, 5);
        check("R6 phase kept over zero inc", n16, 3);

        // R5: 1x strobe exactly on the sixteenth x16 strobe (half-rate step)
        do_reset();
        run_adds(16'h8000, 30);
        check("R5 15 x16 no 1x", n1, 0);
        run_adds(16'h8000, 2);
        check("R5 16th x16 gives 1x", n1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule